// File: doc/BRIEF.md
# Register-Operand Execute Unit with Conditional Skip

This block executes the register-operand instructions of a small 8-bit controller that uses a 13-bit instruction word. The supported operations are increment, decrement with skip on zero, increment with skip on zero, rotate left or right through carry, nibble swap, and clearing, setting or testing a single bit of a register. The block reads one 8-bit operand from an external register file through a combinational read port. The result goes either to the internal accumulator or back to the same register. The Z and C flags are updated according to the operation.

Every instruction takes two clocks, which is one instruction cycle. In the issue clock, marked by `issue_slot`, the block samples the instruction word and the operand. In the execute clock it drives the register-file write port and the skip request. The accumulator and the flags change at the end of the execute clock.

When a skip is taken, `skip_next` pulses for one clock. The next valid instruction is then accepted but executed as a no-op. This is how a taken skip costs one extra instruction cycle.

Top module: `regop_exec_unit`

## Requirements
- R1: After reset release, `issue_slot` alternates high and low on every clock. An instruction is sampled only on a clock where `issue_slot` is high and `instr_valid` is high. Its register write and `skip_next` appear in the following clock, and `acc`, Z and C change only at the end of that clock.
- R2: Group bits [11:8]=0101 with select bits [7:6]=00 (increment into A) or 01 (increment in place) produce operand+1 modulo 256. Z is set exactly when that result is 0, and C is unchanged.
- R3: Group 0101 with select 10 (into A) or 11 (in place) produces operand-1 modulo 256 and requests a skip when the result is 0. Z and C are unchanged.
- R4: Group 0111 with select 10 (into A) or 11 (in place) produces operand+1 modulo 256 and requests a skip when the result is 0. Z and C are unchanged.
- R5: Group 0110 rotates through carry, and only C changes.
  - Select 00 (into A) and 01 (in place) rotate right: operand bit 0 goes to C and the old C goes to result bit 7.
  - Select 10 (into A) and 11 (in place) rotate left: operand bit 7 goes to C and the old C goes to result bit 0.
- R6: Group 0111 with select 00 (into A) or 01 (in place) exchanges the operand's high and low nibbles. Flags are unchanged.
- R7: Bits [11:9]=100 clears, and 101 sets, the operand bit whose index is in bits [8:6]. The result is written back to the register, and flags are unchanged.
- R8: Bits [11:9]=110 requests a skip when the indexed bit is 0, and 111 requests a skip when it is 1. Neither form writes the register, `acc` or the flags.
- R9: In groups 0101 to 0111, bit 6 selects the destination: 1 writes the register at address bits [5:0], and 0 writes `acc`. At most one of the register write and the accumulator write happens for an instruction.
- R10: A taken skip raises `skip_next` for exactly one clock. The next valid instruction, even if it arrives after empty slots, makes no register write, leaves `acc`, Z and C unchanged, and raises no skip.
- R11: A word with bit 12 set, or with bits [11:8] in 0000 to 0100, does nothing.
- R12: During and right after reset, `acc`=0, Z=0 and C=0, and no write and no skip are signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with the clock |
| instr_valid | input | 1 | Instruction word present in this issue slot |
| instr | input | 13 | Instruction word |
| rf_raddr | output | 6 | Register-file read address (instruction bits [5:0]) |
| rf_rdata | input | 8 | Register-file read data for `rf_raddr` |
| rf_we | output | 1 | Register-file write enable (execute clock) |
| rf_waddr | output | 6 | Register-file write address |
| rf_wdata | output | 8 | Register-file write data |
| acc | output | 8 | Accumulator |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| skip_next | output | 1 | One-clock request to squash the next instruction |
| issue_slot | output | 1 | High on clocks where an instruction is sampled |

## Verification
The hardest situations to reach are those where the squash state interacts with what follows it:
- a slot with no valid instruction sitting between the skip and the squashed instruction;
- a squashed instruction that would itself have taken a skip.

The directed stimulus first forces a skip by preloading register values of 1, 0xFF or a chosen bit pattern. It then places an empty slot, or a skip-capable instruction, directly after the skip. A later increment into A reads back the register the squashed instruction targeted, which shows that the register was not touched. A long random run restricts register addresses to a few entries and frequently preloads 0x00, 0x01 and 0xFF, so that skips, dependent operands and carry chains occur often.

// File: rtl/regx_pkg.sv
package regx_pkg;

  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 6;
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int INSTR_W = ADDR_W + BIT_W + 4;
  localparam int HALF_W  = DATA_W / 2;

  typedef enum logic [3:0] {
    OP_NONE    = 4'd0,
    OP_INC     = 4'd1,
    OP_DECSKIP = 4'd2,
    OP_INCSKIP = 4'd3,
    OP_ROTR    = 4'd4,
    OP_ROTL    = 4'd5,
    OP_SWAP    = 4'd6,
    OP_BCLR    = 4'd7,
    OP_BSET    = 4'd8,
    OP_SKIPCLR = 4'd9,
    OP_SKIPSET = 4'd10
  } regx_op_e;

  typedef struct packed {
    regx_op_e            op;
    logic                to_reg;
    logic [BIT_W-1:0]    bidx;
    logic [ADDR_W-1:0]   raddr;
  } regx_dec_t;

endpackage

// File: rtl/regx_decode.sv
module regx_decode
  import regx_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output regx_dec_t          dec
);

  localparam int GRP_HI = INSTR_W - 2;
  localparam int SEL_LO = ADDR_W;

  logic [3:0] grp;
  logic [1:0] sel;
  logic [1:0] bop;

  assign grp = instr[GRP_HI -: 4];
  assign sel = instr[SEL_LO+1 : SEL_LO];
  assign bop = instr[GRP_HI-1 -: 2];

  always_comb begin
    dec.op     = OP_NONE;
    dec.to_reg = instr[SEL_LO];
    dec.bidx   = instr[SEL_LO +: BIT_W];
    dec.raddr  = instr[ADDR_W-1:0];
    if (!instr[INSTR_W-1]) begin
      if (instr[GRP_HI]) begin
        unique case (bop)
          2'b00:   dec.op = OP_BCLR;
          2'b01:   dec.op = OP_BSET;
          2'b10:   dec.op = OP_SKIPCLR;
          default: dec.op = OP_SKIPSET;
        endcase
      end else begin
        unique case (grp)
          4'b0101: dec.op = sel[1] ? OP_DECSKIP : OP_INC;
          4'b0110: dec.op = sel[1] ? OP_ROTL    : OP_ROTR;
          4'b0111: dec.op = sel[1] ? OP_INCSKIP : OP_SWAP;
          default: dec.op = OP_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/regx_alu.sv
module regx_alu
  import regx_pkg::*;
(
  input  regx_op_e          op,
  input  logic              to_reg,
  input  logic [BIT_W-1:0]  bidx,
  input  logic [DATA_W-1:0] opnd,
  input  logic              c_in,
  output logic [DATA_W-1:0] result,
  output logic              c_out,
  output logic              z_out,
  output logic              skip,
  output logic              wr_reg,
  output logic              wr_acc,
  output logic              upd_z,
  output logic              upd_c
);

  logic [DATA_W-1:0] bit_mask;
  logic [DATA_W-1:0] plus_one;
  logic [DATA_W-1:0] minus_one;
  logic              sel_bit;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign bit_mask[g] = (bidx == BIT_W'(g));
  end

  assign plus_one  = opnd + DATA_W'(1);
  assign minus_one = opnd - DATA_W'(1);
  assign sel_bit   = |(opnd & bit_mask);

  always_comb begin
    result = opnd;
    c_out  = c_in;
    skip   = 1'b0;
    wr_reg = 1'b0;
    wr_acc = 1'b0;
    upd_z  = 1'b0;
    upd_c  = 1'b0;
    unique case (op)
      OP_INC: begin
        result = plus_one;
        upd_z  = 1'b1;
        wr_reg = to_reg;
        wr_acc = ~to_reg;
      end
      OP_DECSKIP: begin
        result = minus_one;
        skip   = (minus_one == '0);
        wr_reg = to_reg;
        wr_acc = ~to_reg;
      end
      OP_INCSKIP: begin
        result = plus_one;
        skip   = (plus_one == '0);
        wr_reg = to_reg;
        wr_acc = ~to_reg;
      end
      OP_ROTR: begin
        result = {c_in, opnd[DATA_W-1:1]};
        c_out  = opnd[0];
        upd_c  = 1'b1;
        wr_reg = to_reg;
        wr_acc = ~to_reg;
      end
      OP_ROTL: begin
        result = {opnd[DATA_W-2:0], c_in};
        c_out  = opnd[DATA_W-1];
        upd_c  = 1'b1;
        wr_reg = to_reg;
        wr_acc = ~to_reg;
      end
      OP_SWAP: begin
        result = {opnd[HALF_W-1:0], opnd[DATA_W-1:HALF_W]};
        wr_reg = to_reg;
        wr_acc = ~to_reg;
      end
      OP_BCLR: begin
        result = opnd & ~bit_mask;
        wr_reg = 1'b1;
      end
      OP_BSET: begin
        result = opnd | bit_mask;
        wr_reg = 1'b1;
      end
      OP_SKIPCLR: skip = ~sel_bit;
      OP_SKIPSET: skip = sel_bit;
      default: ;
    endcase
  end

  assign z_out = (result == '0);

endmodule

// File: rtl/regx_ctrl.sv
module regx_ctrl
  import regx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  regx_dec_t         dec_in,
  input  logic [DATA_W-1:0] opnd_in,
  input  logic              skip_taken,
  output logic              core_rst_n,
  output logic              issue_slot,
  output logic              exec_live,
  output regx_dec_t         stg_dec,
  output logic [DATA_W-1:0] stg_opnd
);

  logic [1:0] sync_q;
  logic       phase_q, phase_d;
  logic       stg_en;
  logic       stg_valid_q, stg_sq_q;
  logic       squash_q, squash_d, squash_en;
  regx_dec_t  stg_dec_q;
  logic [DATA_W-1:0] stg_opnd_q;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign core_rst_n = sync_q[1];

  // issue / execute phase
  always_comb phase_d = ~phase_q;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) phase_q <= 1'b0;
    else             phase_q <= phase_d;
  end

  assign issue_slot = core_rst_n & ~phase_q;
  assign stg_en     = issue_slot;

  // instruction stage, loaded in the issue clock
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      stg_valid_q <= 1'b0;
      stg_sq_q    <= 1'b0;
      stg_opnd_q  <= '0;
      stg_dec_q   <= '{op: OP_NONE, default: '0};
    end else if (stg_en) begin
      stg_valid_q <= instr_valid;
      stg_sq_q    <= squash_q;
      stg_opnd_q  <= opnd_in;
      stg_dec_q   <= dec_in;
    end
  end

  // squash state: updated only when a valid instruction executes
  assign squash_en = phase_q & stg_valid_q;
  always_comb squash_d = skip_taken;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)    squash_q <= 1'b0;
    else if (squash_en) squash_q <= squash_d;
  end

  assign exec_live = phase_q & stg_valid_q & ~stg_sq_q;
  assign stg_dec   = stg_dec_q;
  assign stg_opnd  = stg_opnd_q;

endmodule

// File: rtl/regx_arch.sv
module regx_arch
  import regx_pkg::*;
(
  input  logic              clk,
  input  logic              core_rst_n,
  input  logic              acc_en,
  input  logic [DATA_W-1:0] acc_d,
  input  logic              z_en,
  input  logic              z_d,
  input  logic              c_en,
  input  logic              c_d,
  output logic [DATA_W-1:0] acc_q,
  output logic              z_q,
  output logic              c_q
);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  acc_q <= '0;
    else if (acc_en)  acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) z_q <= 1'b0;
    else if (z_en)   z_q <= z_d;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) c_q <= 1'b0;
    else if (c_en)   c_q <= c_d;
  end

endmodule

// File: rtl/regop_exec_unit.sv
module regop_exec_unit
  import regx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  output logic [ADDR_W-1:0]  rf_raddr,
  input  logic [DATA_W-1:0]  rf_rdata,
  output logic               rf_we,
  output logic [ADDR_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0]  rf_wdata,
  output logic [DATA_W-1:0]  acc,
  output logic               flag_z,
  output logic               flag_c,
  output logic               skip_next,
  output logic               issue_slot
);

  regx_dec_t         dec_w, stg_dec;
  logic [DATA_W-1:0] stg_opnd;
  logic              core_rst_n, exec_live;
  logic [DATA_W-1:0] alu_res;
  logic              alu_c, alu_z, alu_skip;
  logic              alu_wr_reg, alu_wr_acc, alu_upd_z, alu_upd_c;
  logic              acc_wr;

  assign rf_raddr = instr[ADDR_W-1:0];

  regx_decode u_decode (
    .instr (instr),
    .dec   (dec_w)
  );

  regx_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .dec_in      (dec_w),
    .opnd_in     (rf_rdata),
    .skip_taken  (skip_next),
    .core_rst_n  (core_rst_n),
    .issue_slot  (issue_slot),
    .exec_live   (exec_live),
    .stg_dec     (stg_dec),
    .stg_opnd    (stg_opnd)
  );

  regx_alu u_alu (
    .op     (stg_dec.op),
    .to_reg (stg_dec.to_reg),
    .bidx   (stg_dec.bidx),
    .opnd   (stg_opnd),
    .c_in   (flag_c),
    .result (alu_res),
    .c_out  (alu_c),
    .z_out  (alu_z),
    .skip   (alu_skip),
    .wr_reg (alu_wr_reg),
    .wr_acc (alu_wr_acc),
    .upd_z  (alu_upd_z),
    .upd_c  (alu_upd_c)
  );

  assign rf_we     = exec_live & alu_wr_reg;
  assign acc_wr    = exec_live & alu_wr_acc;
  assign skip_next = exec_live & alu_skip;
  assign rf_waddr  = stg_dec.raddr;
  assign rf_wdata  = alu_res;

  regx_arch u_arch (
    .clk        (clk),
    .core_rst_n (core_rst_n),
    .acc_en     (acc_wr),
    .acc_d      (alu_res),
    .z_en       (exec_live & alu_upd_z),
    .z_d        (alu_z),
    .c_en       (exec_live & alu_upd_c),
    .c_d        (alu_c),
    .acc_q      (acc),
    .z_q        (flag_z),
    .c_q        (flag_c)
  );

endmodule

// File: rtl/regop_exec_unit_chk.sv
module regop_exec_unit_chk
  import regx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              issue_slot,
  input logic              rf_we,
  input logic              acc_wr,
  input logic              skip_next,
  input logic              flag_z,
  input logic              flag_c,
  input logic [DATA_W-1:0] acc
);

  AST_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && acc_wr)); // R9

  AST_SLOT_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    issue_slot |=> !issue_slot); // R1

  AST_EFFECTS_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || skip_next) |-> !issue_slot); // R1

  AST_STATE_HELD_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    issue_slot |=> ($stable(acc) && $stable(flag_z) && $stable(flag_c))); // R1

  AST_SKIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    skip_next |=> !skip_next); // R10

  AST_SQUASH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    skip_next |-> ##2 (!rf_we && !skip_next && !acc_wr)); // R10

endmodule

bind regop_exec_unit regop_exec_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issue_slot (issue_slot),
  .rf_we      (rf_we),
  .acc_wr     (acc_wr),
  .skip_next  (skip_next),
  .flag_z     (flag_z),
  .flag_c     (flag_c),
  .acc        (acc)
);

// File: tb/regop_exec_unit_tb.sv
module regop_exec_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        instr_valid;
  logic [12:0] instr;
  logic [5:0]  rf_raddr;
  logic [7:0]  rf_rdata;
  logic        rf_we;
  logic [5:0]  rf_waddr;
  logic [7:0]  rf_wdata;
  logic [7:0]  acc;
  logic        flag_z, flag_c, skip_next, issue_slot;

  logic [7:0] rf_mem [64];
  int         m_rf [64];
  int         m_acc, m_z, m_c, m_sq;
  int         n_chk, n_fail;

  regop_exec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .acc(acc),
    .flag_z(flag_z), .flag_c(flag_c), .skip_next(skip_next),
    .issue_slot(issue_slot)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign rf_rdata = rf_mem[rf_raddr];
  always @(posedge clk) if (rf_we === 1'b1) rf_mem[rf_waddr] <= rf_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic poke(input int a, input int v);
    rf_mem[a] = 8'(v);
    m_rf[a]   = v;
  endtask

  // behavioural expectation from the requirement text
  task automatic expect_of(input logic [12:0] ins, input int op, input int cin,
                           output int we, output int wd, output int aw,
                           output int zw, output int zn, output int cw,
                           output int cn, output int sk);
    int grp, sel, b, bv, v;
    we = 0; wd = 0; aw = 0; zw = 0; zn = 0; cw = 0; cn = 0; sk = 0; v = 0;
    grp = int'(ins[11:8]); sel = int'(ins[7:6]);
    if (ins[12]) return;
    if (ins[11]) begin
      b  = int'(ins[8:6]);
      bv = (op >> b) & 1;
      case (int'(ins[10:9]))
        0: begin we = 1; wd = op & ~(1 << b) & 255; end
        1: begin we = 1; wd = op | (1 << b); end
        2: sk = (bv == 0);
        default: sk = (bv == 1);
      endcase
      return;
    end
    if (grp < 5 || grp > 7) return;
    if (grp == 5 && sel < 2) begin v = (op + 1) % 256; zw = 1; zn = (v == 0); end
    else if (grp == 5) begin v = (op + 255) % 256; sk = (v == 0); end
    else if (grp == 6 && sel < 2) begin v = (op / 2) + cin * 128; cw = 1; cn = op % 2; end
    else if (grp == 6) begin v = ((op * 2) % 256) + cin; cw = 1; cn = op / 128; end
    else if (sel < 2) v = (op % 16) * 16 + op / 16;
    else begin v = (op + 1) % 256; sk = (v == 0); end
    if (sel % 2 == 1) begin we = 1; wd = v; end
    else begin aw = 1; wd = v; end
  endtask

  // one instruction cycle; entered just after a negedge of an issue clock
  task automatic run(input bit v, input logic [12:0] ins, input string tag);
    int opnd, sq, we, wd, aw, zw, zn, cw, cn, sk;
    string t;
    instr_valid = v; instr = ins;
    #1;
    chk(issue_slot === 1'b1, "R1", "issue_slot high in issue clock", int'(issue_slot), 1);
    chk(rf_we === 1'b0 && skip_next === 1'b0, "R1", "no effect in issue clock",
        int'({rf_we, skip_next}), 0);
    chk(acc === 8'(m_acc), tag, "acc", int'(acc), m_acc);
    chk(flag_z === 1'(m_z), tag, "flag_z", int'(flag_z), m_z);
    chk(flag_c === 1'(m_c), tag, "flag_c", int'(flag_c), m_c);
    @(posedge clk);
    opnd = m_rf[ins[5:0]];
    sq   = m_sq;
    @(negedge clk);
    instr_valid = 1'b0;
    #1;
    expect_of(ins, opnd, m_c, we, wd, aw, zw, zn, cw, cn, sk);
    t = tag;
    if (!v || sq != 0) begin
      we = 0; aw = 0; zw = 0; cw = 0; sk = 0;
      if (v) t = "R10";
    end
    chk(issue_slot === 1'b0, "R1", "issue_slot low in execute clock", int'(issue_slot), 0);
    chk(rf_we === 1'(we), t, "rf_we", int'(rf_we), we);
    if (we != 0) begin
      chk(rf_waddr === ins[5:0], t, "rf_waddr", int'(rf_waddr), int'(ins[5:0]));
      chk(rf_wdata === 8'(wd), t, "rf_wdata", int'(rf_wdata), wd);
    end
    chk(skip_next === 1'(sk), t, "skip_next", int'(skip_next), sk);
    chk(acc === 8'(m_acc), "R1", "acc held in execute clock", int'(acc), m_acc);
    if (we != 0) m_rf[ins[5:0]] = wd;
    if (aw != 0) m_acc = wd;
    if (zw != 0) m_z = zn;
    if (cw != 0) m_c = cn;
    if (v) m_sq = sk;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [12:0] rop(input int grp, input int sel, input int a);
    return {1'b0, 4'(grp), 2'(sel), 6'(a)};
  endfunction

  function automatic logic [12:0] bop(input int k, input int b, input int a);
    return {1'b0, 1'b1, 2'(k), 3'(b), 6'(a)};
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog expired: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int n;
    n_chk = 0; n_fail = 0;
    m_acc = 0; m_z = 0; m_c = 0; m_sq = 0;
    for (int i = 0; i < 64; i++) poke(i, (i * 37 + 11) % 256);
    rst_n = 1'b0; instr_valid = 1'b0; instr = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(acc === 8'h00 && flag_z === 1'b0 && flag_c === 1'b0, "R12",
        "state in reset", int'({acc, flag_z, flag_c}), 0);
    chk(rf_we === 1'b0 && skip_next === 1'b0 && issue_slot === 1'b0, "R12",
        "no activity in reset", int'({rf_we, skip_next, issue_slot}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk); #1; n++;
    end while (issue_slot !== 1'b1 && n < 10);
    chk(acc === 8'h00 && flag_z === 1'b0 && flag_c === 1'b0, "R12",
        "state after release", int'({acc, flag_z, flag_c}), 0);

    // R2 increment
    poke(1, 8'h41); run(1, rop(5, 0, 1), "R2");
    poke(2, 8'hFF); run(1, rop(5, 1, 2), "R2");
    run(1, rop(5, 0, 2), "R9");
    // R3 decrement-skip then squash R10
    poke(3, 1);     run(1, rop(5, 2, 3), "R3");
    run(1, rop(5, 1, 2), "R10");
    run(1, rop(5, 0, 2), "R10");
    poke(4, 5);     run(1, rop(5, 3, 4), "R3");
    // R4 increment-skip, empty slot between skip and squashed word
    poke(5, 8'hFF); run(1, rop(7, 3, 5), "R4");
    run(0, rop(5, 1, 2), "R10");
    run(1, rop(5, 1, 2), "R10");
    run(1, rop(5, 0, 2), "R10");
    poke(6, 8'h10); run(1, rop(7, 2, 6), "R4");
    // R5 rotates through carry
    poke(7, 8'h01); run(1, rop(6, 0, 7), "R5");
    poke(8, 8'h80); run(1, rop(6, 3, 8), "R5");
    poke(9, 8'h02); run(1, rop(6, 1, 9), "R5");
    run(1, rop(6, 2, 9), "R5");
    // R6 swap
    poke(10, 8'h3C); run(1, rop(7, 0, 10), "R6");
    run(1, rop(7, 1, 10), "R6");
    // R7 bit clear / set
    poke(11, 8'h00); run(1, bop(1, 7, 11), "R7");
    run(1, bop(1, 0, 11), "R7");
    run(1, bop(0, 7, 11), "R7");
    // R8 bit tests
    run(1, bop(2, 0, 11), "R8");
    run(1, bop(2, 3, 11), "R8");
    run(1, bop(1, 4, 11), "R10");
    run(1, bop(3, 0, 11), "R8");
    poke(12, 1);
    run(1, rop(5, 3, 12), "R10");
    run(1, bop(3, 5, 11), "R8");
    // R11 unrecognised words
    run(1, {1'b1, 12'hABC}, "R11");
    run(1, {1'b0, 4'b0000, 8'h55}, "R11");
    run(1, {1'b0, 4'b0100, 8'hC3}, "R11");
    run(1, {1'b0, 4'b0011, 8'hC1}, "R11");

    // R9 random mix over a few registers
    for (int k = 0; k < 600; k++) begin
      int cls, a;
      logic [12:0] w;
      a   = $urandom_range(0, 5);
      cls = $urandom_range(0, 9);
      if ($urandom_range(0, 3) == 0) begin
        case ($urandom_range(0, 2))
          0: poke(a, 0);
          1: poke(a, 1);
          default: poke(a, 255);
        endcase
      end
      if (cls < 6)       w = rop($urandom_range(5, 7), $urandom_range(0, 3), a);
      else if (cls < 9)  w = bop($urandom_range(0, 3), $urandom_range(0, 7), a);
      else               w = {1'b1, 12'($urandom)};
      run($urandom_range(0, 9) != 0, w, "R9");
    end
    run(0, '0, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule